// File: doc/BRIEF.md
# Counter-Driven AES-128 Candidate Search Engine

The engine runs one AES-128 key over a long run of plaintexts at the rate of one block per clock. A plaintext is not supplied from outside. A 128-bit counter produces it on chip, starting from a programmed seed and stepping by one for each block issued. The ten rounds are laid out in space, and each round is cut into four register stages (substitution, row shift, column mix, key add). An initial key-add stage comes before the rounds, so a block takes a fixed 41 cycles from entry to ciphertext.

Each ciphertext that leaves the last stage is compared with a programmable pattern under a programmable mask. Only blocks that agree on every masked bit become candidates. A candidate enters a small FIFO together with the counter value that produced it, and the FIFO drains through a valid/ready port. The key is loaded once per run. A sequential schedule then expands it into the eleven round keys, one per cycle, and a busy flag holds off the start of the run until the expansion is done. When the FIFO fills, the whole pipeline and the counter freeze, so no candidate is lost.

Top module: `aes_search_engine`

## Requirements
- R1: After reset, `outValid` and `busy` are both 0.
- R2: When `busy` is 0, a `keyLoad` pulse latches `keyIn` and raises `busy` for exactly 10 cycles. It also halts block issue until the next accepted `start`. A `keyLoad` while `busy` is 1 is ignored.
- R3: A `start` while `busy` is 1 is ignored. A `start` while `busy` is 0 loads the counter from `seedIn` and begins a run.
- R4: `outCipher` is the AES-128 encryption of `outCounter` under the loaded key. Byte 0 of every block is bits [127:120]. Key 000102..0f with plaintext 00112233..ff gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R5: The counter steps by one for each issued block and wraps modulo 2^128. Candidates leave in counter order.
- R6: Take the case of an empty FIFO, `enable` high and a zero mask. The first candidate raises `outValid` after the 42nd rising edge counted from the edge that samples `start`: 41 pipeline stages plus the FIFO write.
- R7: With a zero mask and `outReady` held high, a new candidate is presented on every cycle once the pipeline is full.
- R8: A ciphertext becomes a candidate if and only if (ct AND `matchMask`) equals (`matchPattern` AND `matchMask`). No matching counter value is skipped, and no non-matching value appears.
- R9: While `outValid` is 1 and `outReady` is 0, `outValid`, `outCounter` and `outCipher` hold. When the FIFO is full, the pipeline and the counter stall, so no candidate is lost or repeated.
- R10: While `enable` is 0, no block is issued, and empty pipeline slots never become candidates, even with a zero mask. When `enable` returns, issue resumes at the next counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| keyLoad | input | 1 | Pulse: latch `keyIn` and expand the round keys |
| keyIn | input | 128 | Cipher key |
| start | input | 1 | Pulse: load the counter from `seedIn` and start a run |
| enable | input | 1 | Level: allow one block to be issued per cycle |
| seedIn | input | 128 | First counter value of a run |
| matchPattern | input | 128 | Value the masked ciphertext must equal |
| matchMask | input | 128 | Bits that take part in the comparison |
| busy | output | 1 | Key expansion in progress |
| outValid | output | 1 | A candidate is presented |
| outReady | input | 1 | Consumer takes the presented candidate |
| outCounter | output | 128 | Counter value (plaintext) of the candidate |
| outCipher | output | 128 | Ciphertext of the candidate |

## Verification
A wrong S-box value, a missing column mix or a stale round key changes the whole ciphertext. It therefore shows as a `outCipher` mismatch on the very first candidate, 42 cycles after start. A broken valid bit or stall shows in the stream of `outCounter` values: a repeated, skipped or unexpected counter value appears on the next candidate after the fault, or a candidate appears during a pause with a zero mask. With a sparse mask, a missed match is found when the next candidate carries a later counter than the bench's own scan predicts.

// File: rtl/aes_srch_pkg.sv
package aes_srch_pkg;

  localparam int NR = 10;
  localparam int STG_PER_RND = 4;

  typedef logic [127:0] blk_t;

  typedef struct packed {
    logic adv;
    logic issue;
  } dp_strb_t;

  function automatic logic [7:0] xt(input logic [7:0] x);
    return {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] x;
    p = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  // inverse as a^254 = a^2 * a^4 * ... * a^128
  function automatic logic [7:0] gfInv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] acc;
    sq  = gfMul(a, a);
    acc = sq;
    for (int i = 0; i < 6; i++) begin
      sq  = gfMul(sq, sq);
      acc = gfMul(acc, sq);
    end
    return acc;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] b;
    b = gfInv(a);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  function automatic blk_t subBytes(input blk_t s);
    blk_t o;
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = sbox(s[127-8*i -: 8]);
    return o;
  endfunction

  function automatic blk_t shiftRows(input blk_t s);
    blk_t o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127-8*(4*c+r) -: 8] = s[127-8*(4*((c+r)%4)+r) -: 8];
    return o;
  endfunction

  function automatic blk_t mixColumns(input blk_t s);
    blk_t o;
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = s[127-32*c -: 8];
      a1 = s[119-32*c -: 8];
      a2 = s[111-32*c -: 8];
      a3 = s[103-32*c -: 8];
      o[127-32*c -: 8] = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
      o[119-32*c -: 8] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
      o[111-32*c -: 8] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
      o[103-32*c -: 8] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
    end
    return o;
  endfunction

  function automatic blk_t keyStep(input blk_t k, input logic [7:0] rc);
    logic [31:0] w0, w1, w2, w3, t;
    w0 = k[127:96];
    w1 = k[95:64];
    w2 = k[63:32];
    w3 = k[31:0];
    t  = {sbox(w3[23:16]) ^ rc, sbox(w3[15:8]), sbox(w3[7:0]), sbox(w3[31:24])};
    w0 = w0 ^ t;
    w1 = w1 ^ w0;
    w2 = w2 ^ w1;
    w3 = w3 ^ w2;
    return {w0, w1, w2, w3};
  endfunction

endpackage

// File: rtl/aes_srch_round.sv
module aes_srch_round
  import aes_srch_pkg::*;
#(
  parameter bit FINAL = 1'b0
) (
  input  logic clk,
  input  logic adv,
  input  blk_t dIn,
  input  blk_t rk,
  output blk_t dOut
);

  blk_t sSub, sShf, sMix, sKey;

  always_ff @(posedge clk) begin
    if (adv) begin
      sSub <= subBytes(dIn);
      sShf <= shiftRows(sSub);
      sKey <= sMix ^ rk;
    end
  end

  generate
    if (FINAL) begin : g_noMix
      always_ff @(posedge clk) if (adv) sMix <= sShf;
    end else begin : g_mix
      always_ff @(posedge clk) if (adv) sMix <= mixColumns(sShf);
    end
  endgenerate

  assign dOut = sKey;

endmodule

// File: rtl/aes_srch_datapath.sv
module aes_srch_datapath
  import aes_srch_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  dp_strb_t strb,
  input  blk_t     ptIn,
  input  blk_t     rk [NR+1],
  output blk_t     ctOut,
  output blk_t     tagOut,
  output logic     vOut
);

  localparam int LAT = 1 + NR * STG_PER_RND;

  logic [LAT-1:0] vPipe;
  blk_t tagPipe [LAT];
  blk_t rndState [NR+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vPipe <= '0;
    else if (strb.adv) vPipe <= {vPipe[LAT-2:0], strb.issue};
  end

  always_ff @(posedge clk) begin
    if (strb.adv) begin
      rndState[0] <= ptIn ^ rk[0];
      tagPipe[0]  <= ptIn;
      for (int i = 1; i < LAT; i++) tagPipe[i] <= tagPipe[i-1];
    end
  end

  generate
    for (genvar r = 0; r < NR; r++) begin : g_rnd
      aes_srch_round #(.FINAL(r == NR-1)) u_rnd (
        .clk  (clk),
        .adv  (strb.adv),
        .dIn  (rndState[r]),
        .rk   (rk[r+1]),
        .dOut (rndState[r+1])
      );
    end
  endgenerate

  assign ctOut  = rndState[NR];
  assign tagOut = tagPipe[LAT-1];
  assign vOut   = vPipe[LAT-1];

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.adv |=> ($stable(vOut) && $stable(tagOut) && $stable(ctOut)))
    else $error("pipeline moved during stall"); // R9

endmodule

// File: rtl/aes_srch_ctrl.sv
module aes_srch_ctrl
  import aes_srch_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     keyLoad,
  input  blk_t     keyIn,
  input  logic     start,
  input  logic     enable,
  input  blk_t     seedIn,
  input  blk_t     matchPattern,
  input  blk_t     matchMask,
  input  logic     dpValid,
  input  blk_t     dpCt,
  input  blk_t     dpTag,
  input  logic     outReady,
  output dp_strb_t strb,
  output blk_t     ptOut,
  output blk_t     rk [NR+1],
  output logic     busy,
  output logic     outValid,
  output blk_t     outTag,
  output blk_t     outCt
);

  localparam int IDX_W = $clog2(NR + 1);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  // key schedule
  logic             busyQ;
  logic [IDX_W-1:0] rkIdx;
  logic [7:0]       rcon;
  blk_t             rkLast, nextKey;
  logic             keyAccept;

  assign keyAccept = keyLoad && !busyQ;
  assign nextKey   = keyStep(rkLast, rcon);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      rkIdx <= '0;
      rcon  <= 8'h01;
    end else if (keyAccept) begin
      busyQ <= 1'b1;
      rkIdx <= IDX_W'(1);
      rcon  <= 8'h01;
    end else if (busyQ) begin
      rcon  <= xt(rcon);
      rkIdx <= rkIdx + 1'b1;
      if (rkIdx == IDX_W'(NR)) busyQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (keyAccept) begin
      rk[0]  <= keyIn;
      rkLast <= keyIn;
    end else if (busyQ) begin
      rkLast <= nextKey;
    end
    for (int i = 1; i <= NR; i++)
      if (busyQ && rkIdx == IDX_W'(i)) rk[i] <= nextKey;
  end

  // run control and counter
  logic running, fifoFull, issue;
  blk_t ctr;

  assign issue = running && enable && !busyQ && !fifoFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      ctr     <= '0;
    end else if (keyAccept) begin
      running <= 1'b0;
    end else if (start && !busyQ) begin
      running <= 1'b1;
      ctr     <= seedIn;
    end else if (issue) begin
      ctr     <= ctr + 128'd1;
    end
  end

  assign strb  = '{adv: !fifoFull, issue: issue};
  assign ptOut = ctr;
  assign busy  = busyQ;

  // match filter and candidate FIFO
  logic             isMatch, push, pop;
  logic [PTR_W-1:0] wPtr, rPtr;
  logic [CNT_W-1:0] fCnt;
  blk_t             fTag [FIFO_DEPTH];
  blk_t             fCt  [FIFO_DEPTH];

  assign isMatch  = ((dpCt ^ matchPattern) & matchMask) == '0;
  assign fifoFull = fCnt == CNT_W'(FIFO_DEPTH);
  assign push     = dpValid && isMatch && !fifoFull;
  assign outValid = fCnt != '0;
  assign pop      = outValid && outReady;

  function automatic logic [PTR_W-1:0] ptrNext(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wPtr <= '0;
      rPtr <= '0;
      fCnt <= '0;
    end else begin
      if (push) wPtr <= ptrNext(wPtr);
      if (pop)  rPtr <= ptrNext(rPtr);
      case ({push, pop})
        2'b10:   fCnt <= fCnt + 1'b1;
        2'b01:   fCnt <= fCnt - 1'b1;
        default: fCnt <= fCnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      fTag[wPtr] <= dpTag;
      fCt[wPtr]  <= dpCt;
    end
  end

  assign outTag = fTag[rPtr];
  assign outCt  = fCt[rPtr];

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outTag) && $stable(outCt)))
    else $error("candidate changed while stalled"); // R9

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fCnt <= CNT_W'(FIFO_DEPTH))
    else $error("candidate FIFO overflow"); // R9

  AST_KEY_BUSY_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |=> busyQ)
    else $error("key expansion ended early"); // R2

endmodule

// File: rtl/aes_search_engine.sv
module aes_search_engine
  import aes_srch_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         keyLoad,
  input  logic [127:0] keyIn,
  input  logic         start,
  input  logic         enable,
  input  logic [127:0] seedIn,
  input  logic [127:0] matchPattern,
  input  logic [127:0] matchMask,
  output logic         busy,
  output logic         outValid,
  input  logic         outReady,
  output logic [127:0] outCounter,
  output logic [127:0] outCipher
);

  dp_strb_t strb;
  blk_t     ptBus, ctBus, tagBus;
  blk_t     rkBus [NR+1];
  logic     dpValid;

  aes_srch_ctrl #(.FIFO_DEPTH(FIFO_DEPTH)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .keyLoad      (keyLoad),
    .keyIn        (keyIn),
    .start        (start),
    .enable       (enable),
    .seedIn       (seedIn),
    .matchPattern (matchPattern),
    .matchMask    (matchMask),
    .dpValid      (dpValid),
    .dpCt         (ctBus),
    .dpTag        (tagBus),
    .outReady     (outReady),
    .strb         (strb),
    .ptOut        (ptBus),
    .rk           (rkBus),
    .busy         (busy),
    .outValid     (outValid),
    .outTag       (outCounter),
    .outCt        (outCipher)
  );

  aes_srch_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .ptIn   (ptBus),
    .rk     (rkBus),
    .ctOut  (ctBus),
    .tagOut (tagBus),
    .vOut   (dpValid)
  );

  AST_BUSY_NO_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.issue)
    else $error("block issued during key expansion"); // R3

endmodule

// File: tb/sim_aes_search_engine.sv
module sim_aes_search_engine;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         keyLoad = 1'b0;
  logic [127:0] keyIn = '0;
  logic         start = 1'b0;
  logic         enable = 1'b0;
  logic [127:0] seedIn = '0;
  logic [127:0] matchPattern = '0;
  logic [127:0] matchMask = '0;
  logic         busy, outValid;
  logic         outReady = 1'b1;
  logic [127:0] outCounter, outCipher;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  logic [7:0]   sb [256];
  logic [127:0] keyB, patB, mskB;

  localparam logic [127:0] FIPS_KEY = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] FIPS_PT  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] FIPS_CT  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;

  always #10 clk = ~clk;

  aes_search_engine u0 (
    .clk(clk), .rstN(rstN), .keyLoad(keyLoad), .keyIn(keyIn), .start(start),
    .enable(enable), .seedIn(seedIn), .matchPattern(matchPattern),
    .matchMask(matchMask), .busy(busy), .outValid(outValid), .outReady(outReady),
    .outCounter(outCounter), .outCipher(outCipher)
  );

  // ---------------- reference model ----------------
  function automatic logic [7:0] mulB(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc = 8'h00;
    logic [7:0] v = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc ^= v;
      v = v[7] ? ((v << 1) ^ 8'h1b) : (v << 1);
    end
    return acc;
  endfunction

  task automatic buildSbox();
    for (int a = 0; a < 256; a++) begin
      logic [7:0] inv = 8'h00;
      logic [7:0] s;
      for (int b = 1; b < 256; b++)
        if (mulB(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      for (int k = 0; k < 8; k++)
        s[k] = inv[k] ^ inv[(k+4)%8] ^ inv[(k+5)%8] ^ inv[(k+6)%8] ^ inv[(k+7)%8];
      sb[a] = s ^ 8'h63;
    end
  endtask

  function automatic logic [127:0] refEnc(input logic [127:0] key, input logic [127:0] pt);
    logic [7:0] w [176];
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] rc = 8'h01;
    logic [127:0] res;
    for (int i = 0; i < 16; i++) w[i] = key[127-8*i -: 8];
    for (int i = 16; i < 176; i += 4) begin
      logic [7:0] tmp [4];
      for (int j = 0; j < 4; j++) tmp[j] = w[i-4+j];
      if (i % 16 == 0) begin
        tmp[0] = sb[w[i-3]] ^ rc;
        tmp[1] = sb[w[i-2]];
        tmp[2] = sb[w[i-1]];
        tmp[3] = sb[w[i-4]];
        rc = rc[7] ? ((rc << 1) ^ 8'h1b) : (rc << 1);
      end
      for (int j = 0; j < 4; j++) w[i+j] = w[i-16+j] ^ tmp[j];
    end
    for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ w[i];
    for (int rd = 1; rd <= 10; rd++) begin
      for (int i = 0; i < 16; i++) s[i] = sb[s[i]];
      for (int c = 0; c < 4; c++)
        for (int row = 0; row < 4; row++)
          t[4*c+row] = s[4*((c+row)%4)+row];
      for (int c = 0; c < 4; c++) begin
        if (rd < 10) begin
          s[4*c]   = mulB(8'h02, t[4*c]) ^ mulB(8'h03, t[4*c+1]) ^ t[4*c+2] ^ t[4*c+3];
          s[4*c+1] = t[4*c] ^ mulB(8'h02, t[4*c+1]) ^ mulB(8'h03, t[4*c+2]) ^ t[4*c+3];
          s[4*c+2] = t[4*c] ^ t[4*c+1] ^ mulB(8'h02, t[4*c+2]) ^ mulB(8'h03, t[4*c+3]);
          s[4*c+3] = mulB(8'h03, t[4*c]) ^ t[4*c+1] ^ t[4*c+2] ^ mulB(8'h02, t[4*c+3]);
        end else begin
          for (int row = 0; row < 4; row++) s[4*c+row] = t[4*c+row];
        end
      end
      for (int i = 0; i < 16; i++) s[i] ^= w[16*rd+i];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  function automatic logic [127:0] nextMatch(input logic [127:0] from);
    logic [127:0] c = from;
    for (int n = 0; n < 4096; n++) begin
      if (((refEnc(keyB, c) ^ patB) & mskB) == '0) return c;
      c = c + 128'd1;
    end
    return c;
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // outReady must be high; checks every candidate against the model
  task automatic collect(input int n, input string req, inout logic [127:0] nxt, output int got);
    got = 0;
    for (int k = 0; k < n; k++) begin
      if (outValid) begin
        logic [127:0] expTag = nextMatch(nxt);
        chk(outCounter == expTag, {req, " counter order"}, outCounter, expTag);
        chk(outCipher == refEnc(keyB, outCounter), "R4 ciphertext", outCipher, refEnc(keyB, outCounter));
        nxt = outCounter + 128'd1;
        got++;
      end
      @(negedge clk);
    end
  endtask

  task automatic loadKey(input logic [127:0] k);
    keyIn = k; keyLoad = 1'b1;
    step(1);
    keyLoad = 1'b0;
    keyB = k;
  endtask

  task automatic startRun(input logic [127:0] sd);
    seedIn = sd; start = 1'b1;
    step(1);
    start = 1'b0;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [127:0] nxt;
    logic [127:0] holdTag, holdCt;
    int got, bad;
    void'($urandom(32'd2024));
    buildSbox();
    chk(refEnc(FIPS_KEY, FIPS_PT) == FIPS_CT, "R4 model", refEnc(FIPS_KEY, FIPS_PT), FIPS_CT);
    patB = '0; mskB = '0;

    step(3);
    rstN = 1'b1;
    step(1);
    chk(outValid == 1'b0, "R1 outValid", 128'(outValid), 0);
    chk(busy == 1'b0, "R1 busy", 128'(busy), 0);

    // R2: busy length, junk load during busy ignored; R3: start during busy ignored
    keyIn = FIPS_KEY; keyLoad = 1'b1; keyB = FIPS_KEY;
    bad = 0;
    for (int k = 1; k <= 11; k++) begin
      @(negedge clk);
      if (k == 1) keyLoad = 1'b0;
      if (k == 3) begin keyLoad = 1'b1; keyIn = ~FIPS_KEY; start = 1'b1; seedIn = 128'h5; end
      if (k == 4) begin keyLoad = 1'b0; start = 1'b0; end
      if (busy != (k <= 10)) bad++;
    end
    chk(bad == 0, "R2 busy length", 128'(bad), 0);
    enable = 1'b1;
    bad = 0;
    for (int k = 0; k < 60; k++) begin if (outValid) bad++; step(1); end
    chk(bad == 0, "R3 start during busy", 128'(bad), 0);

    // R6 latency, R4 known vector
    seedIn = FIPS_PT; start = 1'b1;
    for (int k = 1; k <= 43; k++) begin
      @(negedge clk);
      if (k == 1) start = 1'b0;
      if (k == 42) chk(outValid == 1'b0, "R6 before 42nd edge", 128'(outValid), 0);
      if (k == 43) chk(outValid == 1'b1, "R6 at 42nd edge", 128'(outValid), 1);
    end
    chk(outCounter == FIPS_PT, "R5 first counter is seed", outCounter, FIPS_PT);
    chk(outCipher == FIPS_CT, "R4 known vector", outCipher, FIPS_CT);

    // R7 one per cycle
    nxt = FIPS_PT;
    collect(30, "R7", nxt, got);
    chk(got == 30, "R7 throughput", 128'(got), 30);

    // R9 backpressure
    outReady = 1'b0;
    holdTag = outCounter; holdCt = outCipher;
    bad = 0;
    for (int k = 0; k < 80; k++) begin
      step(1);
      if (!outValid || outCounter != holdTag || outCipher != holdCt) bad++;
    end
    chk(bad == 0, "R9 hold while not ready", 128'(bad), 0);
    outReady = 1'b1;
    collect(60, "R9", nxt, got);
    chk(got > 50, "R9 resume", 128'(got), 51);

    // R10 pause and resume, bubbles ignored
    enable = 1'b0;
    collect(8, "R10", nxt, got);
    enable = 1'b1;
    collect(60, "R10", nxt, got);
    enable = 1'b0;
    collect(60, "R10", nxt, got);
    bad = 0;
    for (int k = 0; k < 30; k++) begin if (outValid) bad++; step(1); end
    chk(bad == 0, "R10 bubbles ignored", 128'(bad), 0);

    // R5 wrap
    startRun('1);
    enable = 1'b1;
    nxt = '1;
    collect(50, "R5 wrap", nxt, got);
    chk(nxt > 128'd3 && nxt < 128'd20, "R5 wrap crossed zero", nxt, 128'd5);
    enable = 1'b0;
    collect(60, "R5", nxt, got);

    // R2 key load halts issue
    loadKey({$urandom, $urandom, $urandom, $urandom});
    step(12);
    enable = 1'b1;
    bad = 0;
    for (int k = 0; k < 70; k++) begin if (outValid) bad++; step(1); end
    chk(bad == 0, "R2 load halts run", 128'(bad), 0);

    // R8 random patterns with sparse masks
    for (int it = 0; it < 2; it++) begin
      enable = 1'b0;
      step(2);
      mskB = '0;
      for (int b = 0; b < 4; b++) mskB[$urandom % 128] = 1'b1;
      patB = {$urandom, $urandom, $urandom, $urandom};
      matchMask = mskB; matchPattern = patB;
      nxt = {$urandom, $urandom, $urandom, $urandom};
      startRun(nxt);
      enable = 1'b1;
      collect(700, "R8", nxt, got);
      chk(got > 0, "R8 candidates seen", 128'(got), 1);
      enable = 1'b0;
      collect(60, "R8", nxt, got);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule